// File: doc/BRIEF.md
# Immediate-Operand ALU Unit

This unit executes three undocumented 8-bit CPU instructions that take an immediate byte: a mask-and-rotate, a masked subtract into the index register, and a load of the same byte into both the accumulator and the index register. The caller presents an operation code, the immediate byte, the current accumulator, the index register and the status byte, and pulses `start`. One clock later the unit presents the new accumulator, index and status values together with a one-cycle `valid` strobe.

The unit has no state beyond its result registers. Operand fetch, opcode decoding, decimal arithmetic and the unstable analog forms of these instructions belong elsewhere. A fourth operation code copies the inputs straight through. A sequencer can then issue it without changing any architectural value.

Top module: `imm_alu_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, `valid`, `a_out`, `x_out` and `p_out` become zero.
- R2: `valid` is 1 in the cycle after a clock edge that samples `start`=1, and 0 in the cycle after an edge that samples `start`=0.
- R3: When `start` is 0, `a_out`, `x_out` and `p_out` hold their values whatever the other inputs do.
- R4: Operation code 0 (mask-rotate) sets `a_out` to (`a_in` AND `imm`) rotated right by one bit, with the incoming carry (`p_in` bit 0) entering bit 7. `x_out` equals `x_in`.
- R5: For operation code 0, status bit 7 (N) is bit 7 of the result and status bit 1 (Z) is 1 when the result is zero. Status bit 0 (C) is result bit 6, and status bit 6 (V) is result bit 6 XOR result bit 5.
- R6: Operation code 1 (masked subtract) sets `x_out` to (`a_in` AND `x_in`) minus `imm`, modulo 256. `a_out` equals `a_in`.
- R7: For operation code 1, C is 1 when (`a_in` AND `x_in`) is at least `imm`, without sign. N and Z come from the new `x_out`, and V keeps its input value.
- R8: Operation code 2 (dual load) sets both `a_out` and `x_out` to `imm`. N and Z come from `imm`, and C and V keep their input values.
- R9: Status bits 5 to 2, which include the decimal flag at bit 3, pass from `p_in` to `p_out` unchanged for every operation code. The decimal flag has no effect on any result.
- R10: Operation code 3 copies `a_in`, `x_in` and `p_in` unchanged to `a_out`, `x_out` and `p_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Executes the selected operation on this edge |
| op | input | 2 | Operation code: 0 mask-rotate, 1 masked subtract, 2 dual load, 3 pass |
| imm | input | 8 | Immediate operand byte |
| a_in | input | 8 | Current accumulator |
| x_in | input | 8 | Current index register |
| p_in | input | 8 | Current status byte (N=7, V=6, Z=1, C=0) |
| valid | output | 1 | Result strobe, one cycle after start |
| a_out | output | 8 | New accumulator |
| x_out | output | 8 | New index register |
| p_out | output | 8 | New status byte |

## Verification
Two things can happen in the same cycle: the unit presents one result with `valid` high, and a new `start` samples the next operation. The bench issues every sweep operation on consecutive cycles without a gap, so each result is checked one cycle after its own start while the next start is already being taken. The bench computes each expected value with its own arithmetic from that operation's inputs. A result that lags or leaks from one operation into the next therefore fails the check. Separate idle cycles with changing inputs confirm that the registers hold once the starts stop.

// File: rtl/imm_alu_pkg.sv
// Shared definitions for the immediate-operand ALU unit.
// Assumes the standard status byte layout: N=7, V=6, Z=1, C=0.
package imm_alu_pkg;
    localparam int PW    = 8;
    localparam int P_N   = 7;
    localparam int P_V   = 6;
    localparam int P_Z   = 1;
    localparam int P_C   = 0;

    typedef enum logic [1:0] {
        OP_MASK_ROT = 2'd0,
        OP_MASK_SUB = 2'd1,
        OP_DUAL_LD  = 2'd2,
        OP_PASS     = 2'd3
    } alu_op_e;
endpackage

// File: rtl/imm_rot_unit.sv
// Mask-and-rotate datapath: ANDs the operand with the immediate byte and
// rotates the masked value right through the carry. It derives C and V
// from result bits 6 and 5. Assumes DW >= 3.
module imm_rot_unit #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] opnd,
    input  logic [DW-1:0] imm,
    input  logic          c_in,
    output logic [DW-1:0] res,
    output logic          c_out,
    output logic          v_out
);
    localparam int BHI = DW - 2;
    localparam int BLO = DW - 3;

    logic [DW-1:0] masked;

    // Mask, rotate and derive the two special flags.
    always_comb begin
        masked = opnd & imm;
        res    = DW'({c_in, masked} >> 1);
        c_out  = res[BHI];
        v_out  = res[BHI] ^ res[BLO];
    end
endmodule

// File: rtl/imm_masksub_unit.sv
// Masked subtract datapath: subtracts the immediate byte from (A AND X).
// The no-borrow flag follows the compare convention.
// Assumes the result is taken modulo 2**DW.
module imm_masksub_unit #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] imm,
    output logic [DW-1:0] res,
    output logic          no_borrow
);
    logic [DW:0] diff;

    // Extended subtract so the borrow appears in the top bit.
    always_comb begin
        diff      = {1'b0, a & x} - {1'b0, imm};
        res       = diff[DW-1:0];
        no_borrow = ~diff[DW];
    end
endmodule

// File: rtl/imm_alu_core.sv
// Immediate-operand ALU unit top. It selects one of three operations or a
// pass-through and registers A, X and the status byte on start. A valid
// strobe follows one cycle later. Assumes 8-bit data and status.
module imm_alu_core #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [DW-1:0] imm,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] x_in,
    input  logic [7:0]    p_in,
    output logic          valid,
    output logic [DW-1:0] a_out,
    output logic [DW-1:0] x_out,
    output logic [7:0]    p_out
);
    import imm_alu_pkg::*;

    localparam int MSB = DW - 1;

    logic [DW-1:0] rot_res, sub_res;
    logic          rot_c, rot_v, sub_c;
    logic [DW-1:0] a_nx, x_nx;
    logic [7:0]    p_nx;
    logic [DW-1:0] a_q, x_q;
    logic [7:0]    p_q;
    logic          v_q;
    alu_op_e       op_e;

    imm_rot_unit #(.DW(DW)) u_rot (
        .opnd  (a_in),
        .imm   (imm),
        .c_in  (p_in[P_C]),
        .res   (rot_res),
        .c_out (rot_c),
        .v_out (rot_v)
    );

    imm_masksub_unit #(.DW(DW)) u_sub (
        .a         (a_in),
        .x         (x_in),
        .imm       (imm),
        .res       (sub_res),
        .no_borrow (sub_c)
    );

    // Pick the next A, X and status from the operation code.
    always_comb begin
        op_e = alu_op_e'(op);
        a_nx = a_in;
        x_nx = x_in;
        p_nx = p_in;
        case (op_e)
            OP_MASK_ROT: begin
                a_nx       = rot_res;
                p_nx[P_N]  = rot_res[MSB];
                p_nx[P_Z]  = (rot_res == '0);
                p_nx[P_C]  = rot_c;
                p_nx[P_V]  = rot_v;
            end
            OP_MASK_SUB: begin
                x_nx       = sub_res;
                p_nx[P_N]  = sub_res[MSB];
                p_nx[P_Z]  = (sub_res == '0);
                p_nx[P_C]  = sub_c;
            end
            OP_DUAL_LD: begin
                a_nx       = imm;
                x_nx       = imm;
                p_nx[P_N]  = imm[MSB];
                p_nx[P_Z]  = (imm == '0);
            end
            default: ;
        endcase
    end

    // Result registers: load on start, hold otherwise, and strobe valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            x_q <= '0;
            p_q <= '0;
            v_q <= 1'b0;
        end else begin
            v_q <= start;
            if (start) begin
                a_q <= a_nx;
                x_q <= x_nx;
                p_q <= p_nx;
            end
        end
    end

    assign valid = v_q;
    assign a_out = a_q;
    assign x_out = x_q;
    assign p_out = p_q;
endmodule

// File: rtl/imm_alu_chk.sv
// Property checker for imm_alu_core, attached with a bind statement.
// It relates the registered outputs to the inputs sampled at start.
module imm_alu_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [1:0]    op,
    input logic [DW-1:0] imm,
    input logic [DW-1:0] a_in,
    input logic [DW-1:0] x_in,
    input logic [7:0]    p_in,
    input logic          valid,
    input logic [DW-1:0] a_out,
    input logic [DW-1:0] x_out,
    input logic [7:0]    p_out
);
    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> valid); // R2
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !start |=> ($stable(a_out) && $stable(x_out) && $stable(p_out))); // R3
    AST_ROT_X_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (start && op == 2'd0) |=> x_out == $past(x_in)); // R4
    AST_ROT_CV: assert property (@(posedge clk) disable iff (!rst_n) (start && op == 2'd0) |=> (p_out[0] == a_out[DW-2] && p_out[6] == (a_out[DW-2] ^ a_out[DW-3]))); // R5
    AST_SUB_A_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (start && op == 2'd1) |=> a_out == $past(a_in)); // R6
    AST_SUB_V_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (start && op == 2'd1) |=> p_out[6] == $past(p_in[6])); // R7
    AST_DUAL_EQUAL: assert property (@(posedge clk) disable iff (!rst_n) (start && op == 2'd2) |=> (a_out == x_out && x_out == $past(imm))); // R8
    AST_MID_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n) start |=> p_out[5:2] == $past(p_in[5:2])); // R9
    AST_PASS_COPY: assert property (@(posedge clk) disable iff (!rst_n) (start && op == 2'd3) |=> (a_out == $past(a_in) && x_out == $past(x_in) && p_out == $past(p_in))); // R10
endmodule

bind imm_alu_core imm_alu_chk #(.DW(DW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .op    (op),
    .imm   (imm),
    .a_in  (a_in),
    .x_in  (x_in),
    .p_in  (p_in),
    .valid (valid),
    .a_out (a_out),
    .x_out (x_out),
    .p_out (p_out)
);

// File: tb/sim_imm_alu_core.sv
// Bench for imm_alu_core. It sweeps the operation codes back to back and
// computes every expected value arithmetically.
module sim_imm_alu_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op = 2'd0;
    logic [7:0] imm = 8'h00, a_in = 8'h00, x_in = 8'h00, p_in = 8'h00;
    logic       valid;
    logic [7:0] a_out, x_out, p_out;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    imm_alu_core u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .imm(imm),
        .a_in(a_in), .x_in(x_in), .p_in(p_in), .valid(valid),
        .a_out(a_out), .x_out(x_out), .p_out(p_out)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // Drive one operation on a falling edge, then check its result after the rising edge.
    task automatic run_op(input logic [1:0] o, input logic [7:0] i, input logic [7:0] a,
                          input logic [7:0] x, input logic [7:0] p);
        logic [7:0] ea, ex, ep, t, r, m, d;
        string rq;
        @(negedge clk);
        start = 1'b1; op = o; imm = i; a_in = a; x_in = x; p_in = p;
        ea = a; ex = x; ep = p;
        case (o)
            2'd0: begin
                t = a & i;
                r = {p[0], t[7:1]};
                ea = r;
                ep = {r[7], r[6] ^ r[5], p[5:2], r == 8'h00, r[6]};
                rq = "R4/R5";
            end
            2'd1: begin
                m = a & x;
                d = m - i;
                ex = d;
                ep = {d[7], p[6], p[5:2], d == 8'h00, m >= i};
                rq = "R6/R7";
            end
            2'd2: begin
                ea = i; ex = i;
                ep = {i[7], p[6], p[5:2], i == 8'h00, p[0]};
                rq = "R8";
            end
            default: rq = "R10";
        endcase
        @(posedge clk);
        #1;
        check("R2", "valid", {7'd0, valid}, 8'h01);
        check(rq, "a_out", a_out, ea);
        check(rq, "x_out", x_out, ex);
        check({rq, "/R9"}, "p_out", p_out, ep);
    endtask

    initial begin
        #(4 * 199000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        if (!finished) $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] ha, hx, hp;
        rst_n = 1'b0;
        start = 1'b1; op = 2'd3; a_in = 8'hA5; x_in = 8'h5A; p_in = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset clears the registers even when start is high.
        check("R1", "valid", {7'd0, valid}, 8'h00);
        check("R1", "a_out", a_out, 8'h00);
        check("R1", "x_out", x_out, 8'h00);
        check("R1", "p_out", p_out, 8'h00);
        @(negedge clk);
        start = 1'b0; rst_n = 1'b1;

        // R4/R5/R9: full sweep of A and imm, carry and middle bits varied.
        for (int a = 0; a < 256; a++)
            for (int i = 0; i < 256; i++)
                run_op(2'd0, 8'(i), 8'(a), 8'(a * 7 + 3), 8'(a ^ (i << 1) ^ (i >> 3)));

        // R6/R7: full sweep of A and imm against a varying X.
        for (int a = 0; a < 256; a++)
            for (int i = 0; i < 256; i++)
                run_op(2'd1, 8'(i), 8'(a), 8'(a * 3 + i), 8'(i ^ (a << 2)));

        // R7 boundaries: equal operands, borrow, zero immediate.
        run_op(2'd1, 8'h10, 8'hFF, 8'h10, 8'h41);
        run_op(2'd1, 8'h01, 8'h00, 8'hFF, 8'h40);
        run_op(2'd1, 8'h00, 8'hF0, 8'h3C, 8'h00);

        // R8: every immediate with two status patterns.
        for (int i = 0; i < 256; i++) begin
            run_op(2'd2, 8'(i), 8'h33, 8'hCC, 8'hC3);
            run_op(2'd2, 8'(i), 8'hCC, 8'h33, 8'h3C);
        end

        // R9: the decimal flag does not change a mask-rotate result.
        run_op(2'd0, 8'hFF, 8'h6B, 8'h00, 8'h09);
        run_op(2'd0, 8'hFF, 8'h6B, 8'h00, 8'h01);

        // R10: pass-through copies the inputs.
        run_op(2'd3, 8'h77, 8'h12, 8'h34, 8'h56);
        run_op(2'd3, 8'h00, 8'hFE, 8'hDC, 8'hBA);

        // R3: idle cycles with changing inputs leave the outputs alone.
        @(negedge clk);
        ha = a_out; hx = x_out; hp = p_out;
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            op = 2'(k); imm = 8'(k * 37); a_in = 8'(k * 91); x_in = 8'(k * 13); p_in = 8'(~k);
            @(posedge clk);
            #1;
            check("R3", "a_out hold", a_out, ha);
            check("R3", "x_out hold", x_out, hx);
            check("R3", "p_out hold", p_out, hp);
            check("R2", "valid idle", {7'd0, valid}, 8'h00);
            @(negedge clk);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule